// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits behind an APB-style slave interface. It holds one output data register and one per-pin direction register. It drives an output-value line and an output-enable line for every pin. The external input pins pass through a two-stage synchroniser before software can see them.

Every access to the data register is filtered by a mask taken from the word-address bits. The eight address bits just above the byte offset pick which pins a read reports and which pins a write may change. Software can therefore set or clear one pin with a single store, with no read-modify-write. A data read reports each selected pin from one of two sources: the driven output value when the pin is an output, or the synchronised input level when the pin is an input.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the direction register and the output data register are both zero, so `pin_oe` and `pin_out` are all zero and every pin is an input.
- R2: A write to the data window (byte offsets 0x000 to 0x3FC) takes `pwdata` bit n into output bit n only where address bit n+2 is 1. Every other output bit keeps its previous value.
- R3: On a read of the data window, each bit whose address bit n+2 is 0 returns 0, whatever the pin level.
- R4: On a read of the data window, a selected bit returns the driven output value when its direction bit is 1, and the synchronised input level when its direction bit is 0.
- R5: A change on `pin_in` reaches the read path after exactly two rising clock edges. After one edge, a read still returns the old level.
- R6: The direction register is at byte offset 0x400 and can be written and read back. Direction bit n set to 1 makes pin n an output, and `pin_oe[n]` equals that bit.
- R7: `pin_out[n]` equals output data bit n. A data write is visible on `pin_out` right after the clock edge that ends its access phase.
- R8: Every transfer completes without wait states: `pready` is always 1 and `pslverr` is always 0.
- R9: A read of any other offset (for example 0x404 or 0x800) returns 0. A write to such an offset changes neither register.
- R10: Byte address 1 << (n+2) reaches pin n alone. Writing 1 << n there drives pin n high, writing 0 drives it low, and the other pins keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Word address (byte address bits 11:2) |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while selected for a read |
| pready | output | 1 | Transfer done, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| pin_in | input | 8 | Asynchronous external pin levels |
| pin_out | output | 8 | Driven output value per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
The masked paths are tried with a full mask, with each nibble on its own, with single-pin masks and with an all-zero mask. These patterns separate a design that ignores the mask from one that inverts it or shifts it by one address bit. Reads are made with mixed directions while the input levels differ from the driven values. This shows whether each selected bit comes from the right source for its direction. The synchroniser is sampled after one edge and again after two, which exposes a missing stage or an extra one. Undecoded offsets next to the direction register and above the data window are written and read, which catches decoding that is too loose.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Which register an access targets
    typedef enum logic [1:0] {
        GSEL_NONE = 2'd0,
        GSEL_DATA = 2'd1,
        GSEL_DIR  = 2'd2
    } gpio_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int WADDR_W = 10
) (
    input  logic [WADDR_W-1:0] waddr,
    output gpio_sel_e          sel,
    output logic [NPINS-1:0]   mask
);
    // Data window covers the word addresses whose bits above the mask are zero;
    // the direction register is the first word past that window.
    localparam int HI_W = WADDR_W - NPINS;
    localparam logic [WADDR_W-1:0] DIR_WORD = WADDR_W'(1) << NPINS;

    always_comb begin
        mask = waddr[NPINS-1:0];
        if (waddr[WADDR_W-1:NPINS] == HI_W'(0)) begin
            sel = GSEL_DATA;
        end else if (waddr == DIR_WORD) begin
            sel = GSEL_DIR;
        end else begin
            sel = GSEL_NONE;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = async_in;
            end else begin : g_next
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_d;
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mask_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_sel_e        sel,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dout,
    output logic [NPINS-1:0] dir
);
    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] dir;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (sel)
                GSEL_DATA: regs_d.dout = (regs_q.dout & ~mask) | (wdata & mask);
                GSEL_DIR:  regs_d.dir  = wdata;
                default:   regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dout = regs_q.dout;
    assign dir  = regs_q.dir;

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int WADDR_W     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [WADDR_W-1:0] paddr,
    input  logic [NPINS-1:0]   pwdata,
    output logic [NPINS-1:0]   prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe
);
    gpio_sel_e        acc_sel;
    logic [NPINS-1:0] acc_mask;
    logic [NPINS-1:0] in_sync;
    logic [NPINS-1:0] dout_q;
    logic [NPINS-1:0] dir_q;
    logic             wr_en;
    logic [NPINS-1:0] pin_level;

    gpio_addr_decode #(.NPINS(NPINS), .WADDR_W(WADDR_W)) u_dec (
        .waddr (paddr),
        .sel   (acc_sel),
        .mask  (acc_mask)
    );

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (pclk),
        .rst_n    (presetn),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    assign wr_en = psel && penable && pwrite;

    gpio_port_regs #(.NPINS(NPINS)) u_regs (
        .clk   (pclk),
        .rst_n (presetn),
        .wr_en (wr_en),
        .sel   (acc_sel),
        .mask  (acc_mask),
        .wdata (pwdata),
        .dout  (dout_q),
        .dir   (dir_q)
    );

    // Per-pin level seen by software: driven value for outputs, synced input otherwise
    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_lvl
            assign pin_level[p] = dir_q[p] ? dout_q[p] : in_sync[p];
        end
    endgenerate

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (acc_sel)
                GSEL_DATA: prdata = pin_level & acc_mask;
                GSEL_DIR:  prdata = dir_q;
                default:   prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int NPINS       = 8,
    parameter int WADDR_W     = 10,
    parameter int SYNC_STAGES = 2
) (
    input logic               pclk,
    input logic               presetn,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [WADDR_W-1:0] paddr,
    input logic [NPINS-1:0]   pwdata,
    input logic [NPINS-1:0]   prdata,
    input logic               pready,
    input logic               pslverr,
    input logic [NPINS-1:0]   pin_out,
    input logic [NPINS-1:0]   pin_oe
);
    localparam int HI_W = WADDR_W - NPINS;
    localparam logic [WADDR_W-1:0] DIR_WORD = WADDR_W'(1) << NPINS;

    logic             in_data_win;
    logic             at_dir;
    logic [NPINS-1:0] amask;

    assign in_data_win = (paddr[WADDR_W-1:NPINS] == HI_W'(0));
    assign at_dir      = (paddr == DIR_WORD);
    assign amask       = paddr[NPINS-1:0];

    // R8: zero-wait, error-free transfers
    a_r8_no_wait: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);

    // R2: selected bits take the written value
    a_r2_masked_take: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && in_data_win)
        |=> ((pin_out & $past(amask)) == ($past(pwdata) & $past(amask))));

    // R2: unselected bits keep their value across a data write
    a_r2_unmasked_hold: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && in_data_win)
        |=> (((pin_out ^ $past(pin_out)) & ~$past(amask)) == '0));

    // R3: read bits outside the mask are zero
    a_r3_mask_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && in_data_win) |-> ((prdata & ~amask) == '0));

    // R6: output enables move only on a direction write
    a_r6_oe_stable: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite && at_dir) |=> $stable(pin_oe));

    // R9: undecoded offsets read as zero
    a_r9_undecoded_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && !in_data_win && !at_dir) |-> (prdata == '0));

    // R9: an undecoded write leaves both registers alone
    a_r9_undecoded_ignored: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && !in_data_win && !at_dir)
        |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .NPINS(NPINS), .WADDR_W(WADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/tb_gpio_mask_port.sv
module tb_gpio_mask_port;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;   // byte address
        logic [7:0]  wdata;
        logic [7:0]  pin;
        logic [7:0]  exp_rd;
        logic [7:0]  exp_out;
        logic [7:0]  exp_oe;
    } vec_t;

    // wr, byte addr, wdata, pin_in, expected read, expected pin_out, expected pin_oe
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h400, 8'hF0, 8'h00, 8'h00, 8'h00, 8'hF0}, // R6 dir write
        '{1'b1, 12'h3FC, 8'hA5, 8'h00, 8'h00, 8'hA5, 8'hF0}, // R2 full mask
        '{1'b0, 12'h3FC, 8'h00, 8'h3C, 8'hAC, 8'hA5, 8'hF0}, // R4 mixed sources
        '{1'b1, 12'h03C, 8'h00, 8'h3C, 8'h00, 8'hA0, 8'hF0}, // R2 low nibble only
        '{1'b0, 12'h03C, 8'h00, 8'h3C, 8'h0C, 8'hA0, 8'hF0}, // R3 low nibble read
        '{1'b0, 12'h3C0, 8'h00, 8'hFF, 8'hA0, 8'hA0, 8'hF0}, // R3 R4 high nibble
        '{1'b1, 12'h020, 8'h08, 8'hFF, 8'h00, 8'hA8, 8'hF0}, // R10 pin 3 high
        '{1'b1, 12'h200, 8'h00, 8'hFF, 8'h00, 8'h28, 8'hF0}, // R10 pin 7 low
        '{1'b0, 12'h200, 8'h00, 8'h00, 8'h00, 8'h28, 8'hF0}, // R10 read pin 7
        '{1'b0, 12'h020, 8'h00, 8'h00, 8'h00, 8'h28, 8'hF0}, // R4 pin 3 input
        '{1'b1, 12'h000, 8'hFF, 8'h00, 8'h00, 8'h28, 8'hF0}, // R2 empty mask
        '{1'b0, 12'h400, 8'h00, 8'h00, 8'hF0, 8'h28, 8'hF0}, // R6 readback
        '{1'b1, 12'h404, 8'hFF, 8'h00, 8'h00, 8'h28, 8'hF0}, // R9 write ignored
        '{1'b0, 12'h404, 8'h00, 8'h00, 8'h00, 8'h28, 8'hF0}, // R9 read zero
        '{1'b0, 12'h800, 8'h00, 8'hFF, 8'h00, 8'h28, 8'hF0}, // R9 above window
        '{1'b1, 12'h400, 8'h0F, 8'h55, 8'h00, 8'h28, 8'h0F}, // R6 flip direction
        '{1'b0, 12'h3FC, 8'h00, 8'h55, 8'h58, 8'h28, 8'h0F}  // R4 after flip
    };

    logic       pclk = 1'b0;
    logic       presetn = 1'b0;
    logic       psel = 1'b0;
    logic       penable = 1'b0;
    logic       pwrite = 1'b0;
    logic [9:0] paddr = '0;
    logic [7:0] pwdata = '0;
    logic [7:0] prdata;
    logic       pready;
    logic       pslverr;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) pclk = ~pclk;

    gpio_mask_port dut (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One APB transfer; for reads returns prdata sampled in the access phase
    task automatic apb(input logic wr, input logic [11:0] addr, input logic [7:0] wd,
                       output logic [7:0] rd);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr[11:2]; pwdata = wd;
        @(posedge pclk);
        @(negedge pclk);
        penable = 1'b1;
        #1;
        rd = prdata;
        check8("R8 pready", {7'd0, pready}, 8'h01);
        check8("R8 pslverr", {7'd0, pslverr}, 8'h00);
        @(posedge pclk);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(posedge pclk);
        @(negedge pclk);
        // R1: reset state
        check8("R1 pin_oe after reset", pin_oe, 8'h00);
        check8("R1 pin_out after reset", pin_out, 8'h00);
        presetn = 1'b1;
        @(negedge pclk);
        check8("R1 pin_oe out of reset", pin_oe, 8'h00);
        check8("R1 pin_out out of reset", pin_out, 8'h00);

        for (int i = 0; i < NV; i++) begin
            pin_in = TBL[i].pin;
            repeat (3) @(posedge pclk);
            apb(TBL[i].wr, TBL[i].addr, TBL[i].wdata, rd);
            if (!TBL[i].wr)
                check8($sformatf("R3 R4 R6 R9 R10 read vec %0d", i), rd, TBL[i].exp_rd);
            check8($sformatf("R2 R7 R9 R10 pin_out vec %0d", i), pin_out, TBL[i].exp_out);
            check8($sformatf("R6 R9 pin_oe vec %0d", i), pin_oe, TBL[i].exp_oe);
        end

        // R5: synchroniser latency. dir=0F, so high nibble is input.
        pin_in = 8'h00;
        repeat (4) @(posedge pclk);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = 10'h0F0; // mask F0
        pin_in = 8'hF0;
        @(posedge pclk);
        @(negedge pclk);
        check8("R5 after one edge", prdata, 8'h00);
        @(posedge pclk);
        @(negedge pclk);
        check8("R5 after two edges", prdata, 8'hF0);
        psel = 1'b0; penable = 1'b0;

        // R7: pin_out changes right after the access edge of a write
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 10'h001; pwdata = 8'h01;
        @(posedge pclk);
        @(negedge pclk);
        penable = 1'b1;
        check8("R7 before access edge", pin_out, 8'h28);
        @(posedge pclk);
        @(negedge pclk);
        check8("R7 after access edge", pin_out, 8'h29);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;

        // R1: reset again clears both registers
        presetn = 1'b0;
        @(negedge pclk);
        check8("R1 re-reset pin_out", pin_out, 8'h00);
        check8("R1 re-reset pin_oe", pin_oe, 8'h00);
        presetn = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule